// File: doc/BRIEF.md
# Concurrent Block-Move Engine with Address Interlock

The engine copies a block of 72-bit words from one address range of an internal memory to another while the processor keeps running. A single command gives the source start address, the destination start address and the word count. The engine then copies the words in ascending order, reading one word and writing it in the next cycle. Addresses wrap modulo 2^15.

The engine owns the single memory port. The processor reaches memory through the engine. The processor presents every access on the request side. The engine stalls any access whose address lies in the part of the source range that has not been copied yet, or in the part of the destination range that has not been written yet. It also stalls any access while the port is busy with a transfer cycle. After each word, if the processor is asking, the engine leaves the port free for one cycle. Processor work therefore goes on during a long transfer, and stalled references proceed once their words have moved.

Controller states: IDLE (port free, waiting for a command), READ (engine reads the source word), WRITE (engine writes the destination word and advances), YIELD (one free port cycle for the processor) and DONE (one cycle: done pulse, interlock already clear). The transitions are:
- IDLE→READ when a command is accepted.
- READ→WRITE always.
- WRITE→DONE on the last word.
- WRITE→YIELD when the processor is requesting.
- WRITE→READ otherwise.
- YIELD→READ always.
- DONE→IDLE always.

Top module: `blkmove_engine`

## Requirements
- R1: A command (`cmd_valid` high while `cmd_busy` is low) is accepted at the clock edge. `cmd_len` holds the word count minus one, so 0 moves 1 word and 32767 moves 32768 words. `cmd_busy` is high from the next cycle.
- R2: After the transfer, destination address (dst+i) mod 2^15 holds the full 72-bit word that was at (src+i) mod 2^15 before the transfer, for every i below the count.
- R3: Each word takes one READ cycle and then one WRITE cycle, in ascending order. With no processor request, `done` is high in the cycle 2N+1 cycles after the accept edge, for N words.
- R4: A processor access to an address outside both remaining ranges is granted while the transfer is still in progress, in the YIELD slot after the current word.
- R5: `cpu_stall` is high, in the same cycle as the request, for any requested address in the uncopied part of the source range or the unwritten part of the destination range.
- R6: A stalled read of a destination word returns the copied data. A stalled write to a source word lands only after that word is copied, so the destination gets the old value.
- R7: A command offered while `cmd_busy` is high is ignored. No extra transfer happens and no extra `done` is produced.
- R8: `done` is high for exactly one cycle, and no address is interlocked in that cycle.
- R9: The engine has priority at the port. In READ and WRITE no processor access is granted. A processor access is granted only in IDLE, YIELD or DONE, and it then drives the memory port.
- R10: The memory port has a one-cycle read latency. `cpu_rvalid` is high in the cycle after a granted processor read, with the data on `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | command strobe |
| cmd_src | input | 15 | source start address |
| cmd_dst | input | 15 | destination start address |
| cmd_len | input | 15 | word count minus one |
| cmd_busy | output | 1 | transfer in progress, commands refused |
| done | output | 1 | one-cycle completion pulse |
| cpu_req | input | 1 | processor access request |
| cpu_we | input | 1 | processor write enable |
| cpu_addr | input | 15 | processor address |
| cpu_wdata | input | 72 | processor write data |
| cpu_stall | output | 1 | request held back this cycle |
| cpu_rvalid | output | 1 | read data valid |
| cpu_rdata | output | 72 | read data |
| mem_en | output | 1 | memory access enable |
| mem_we | output | 1 | memory write enable |
| mem_addr | output | 15 | memory address |
| mem_wdata | output | 72 | memory write data |
| mem_rdata | input | 72 | memory read data, one cycle after the read |

## Verification
Every command is driven for one cycle. The bench counts falling edges from the accept edge until `done`, and compares the count with 2N+1. `cpu_stall` is combinational, so the bench reads it one time step after it changes the request, within the same cycle. A granted read is checked at the next falling edge, where `cpu_rvalid` and the data are due. Memory contents are compared only after `done`, except at a grant, where the destination word must already hold its copied value.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_YIELD,
        ST_DONE
    } mv_state_t;
endpackage

// File: rtl/blkmove_span.sv
// Hit when probe lies in [base, base+remain) modulo 2^AW.
module blkmove_span #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] base,
    input  logic [AW:0]   remain,
    input  logic [AW-1:0] probe,
    output logic          hit
);
    logic [AW-1:0] offset;

    always_comb begin
        offset = probe - base;
        hit    = ({1'b0, offset} < remain);
    end
endmodule

// File: rtl/blkmove_ilock.sv
// Compares a processor address against both remaining ranges.
module blkmove_ilock #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] src_ptr,
    input  logic [AW-1:0] dst_ptr,
    input  logic [AW:0]   remain,
    input  logic [AW-1:0] probe,
    output logic          pending
);
    localparam int NSPAN = 2;

    logic [AW-1:0] bases [NSPAN];
    logic [NSPAN-1:0] hits;

    always_comb begin
        bases[0] = src_ptr;
        bases[1] = dst_ptr;
    end

    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        blkmove_span #(.AW(AW)) u_span (
            .base   (bases[g]),
            .remain (remain),
            .probe  (probe),
            .hit    (hits[g])
        );
    end

    assign pending = |hits;
endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
    import blkmove_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [AW-1:0] cmd_len,
    input  logic          cpu_req,
    input  logic [DW-1:0] rd_word,
    output mv_state_t     state,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [AW:0]   remain,
    output logic          eng_en,
    output logic          eng_we,
    output logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_wdata,
    output logic          busy,
    output logic          done,
    output logic          slot_open
);
    mv_state_t state_nx;
    logic      last_word;

    assign last_word = (remain == {{AW{1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: begin
                if (last_word)    state_nx = ST_DONE;
                else if (cpu_req) state_nx = ST_YIELD;
                else              state_nx = ST_READ;
            end
            ST_YIELD: state_nx = ST_READ;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            remain  <= '0;
        end else if (state == ST_IDLE && cmd_valid) begin
            src_ptr <= cmd_src;
            dst_ptr <= cmd_dst;
            remain  <= {1'b0, cmd_len} + 1'b1;
        end else if (state == ST_WRITE) begin
            src_ptr <= src_ptr + 1'b1;
            dst_ptr <= dst_ptr + 1'b1;
            remain  <= remain - 1'b1;
        end
    end

    always_comb begin
        eng_en    = 1'b0;
        eng_we    = 1'b0;
        eng_addr  = src_ptr;
        eng_wdata = rd_word;
        busy      = 1'b1;
        done      = 1'b0;
        slot_open = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                slot_open = 1'b1;
            end
            ST_READ: begin
                eng_en   = 1'b1;
                eng_addr = src_ptr;
            end
            ST_WRITE: begin
                eng_en   = 1'b1;
                eng_we   = 1'b1;
                eng_addr = dst_ptr;
            end
            ST_YIELD: slot_open = 1'b1;
            ST_DONE: begin
                done      = 1'b1;
                slot_open = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/blkmove_portmux.sv
module blkmove_portmux #(
    parameter int AW = 15,
    parameter int DW = 72
) (
    input  logic          cpu_sel,
    input  logic          eng_en,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    always_comb begin
        if (cpu_sel) begin
            mem_en    = 1'b1;
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else begin
            mem_en    = eng_en;
            mem_we    = eng_we;
            mem_addr  = eng_addr;
            mem_wdata = eng_wdata;
        end
    end
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
    import blkmove_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [AW-1:0] cmd_len,
    output logic          cmd_busy,
    output logic          done,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    mv_state_t     state_w;
    logic [AW-1:0] src_ptr_w;
    logic [AW-1:0] dst_ptr_w;
    logic [AW:0]   remain_w;
    logic          eng_en, eng_we;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata;
    logic          slot_open;
    logic          pending_w;
    logic          cpu_gnt;

    blkmove_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_src   (cmd_src),
        .cmd_dst   (cmd_dst),
        .cmd_len   (cmd_len),
        .cpu_req   (cpu_req),
        .rd_word   (mem_rdata),
        .state     (state_w),
        .src_ptr   (src_ptr_w),
        .dst_ptr   (dst_ptr_w),
        .remain    (remain_w),
        .eng_en    (eng_en),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .busy      (cmd_busy),
        .done      (done),
        .slot_open (slot_open)
    );

    blkmove_ilock #(.AW(AW)) u_ilock (
        .src_ptr (src_ptr_w),
        .dst_ptr (dst_ptr_w),
        .remain  (remain_w),
        .probe   (cpu_addr),
        .pending (pending_w)
    );

    assign cpu_gnt   = cpu_req && slot_open && !pending_w;
    assign cpu_stall = cpu_req && !cpu_gnt;
    assign cpu_rdata = mem_rdata;

    blkmove_portmux #(.AW(AW), .DW(DW)) u_mux (
        .cpu_sel   (cpu_gnt),
        .eng_en    (eng_en),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cpu_rvalid <= 1'b0;
        else        cpu_rvalid <= cpu_gnt && !cpu_we;
    end
endmodule

// File: rtl/blkmove_checker.sv
module blkmove_checker
    import blkmove_pkg::*;
#(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [AW-1:0] cmd_len,
    input logic          cmd_busy,
    input logic          done,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_stall,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input mv_state_t     state_w,
    input logic [AW:0]   remain_w,
    input logic          pending_w
);
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_busy && cmd_valid) |=> (cmd_busy && remain_w == $past({1'b0, cmd_len}) + 1'b1));

    p_write_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_WRITE) |=> (remain_w == $past(remain_w) - 1'b1));

    p_stall_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && pending_w) |-> cpu_stall);

    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && cmd_valid) |=> (remain_w <= $past(remain_w)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pending_w);

    p_engine_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_READ || state_w == ST_WRITE) |-> (cpu_stall || !cpu_req));

    p_grant_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_stall) |-> (mem_en && mem_we == cpu_we && mem_addr == cpu_addr));
endmodule

bind blkmove_engine blkmove_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_len   (cmd_len),
    .cmd_busy  (cmd_busy),
    .done      (done),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .state_w   (state_w),
    .remain_w  (remain_w),
    .pending_w (pending_w)
);

// File: tb/blkmove_engine_bench.sv
`timescale 1ns/1ps
module blkmove_engine_bench;
    localparam int AW = 15;
    localparam int DW = 72;
    localparam int MW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_src = '0, cmd_dst = '0, cmd_len = '0;
    logic          cmd_busy, done;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_stall, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] bmem [MW];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    blkmove_engine u_blkmove_engine (.*);

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[9:0]];
        end
    end

    function automatic logic [DW-1:0] patt(int a);
        logic [31:0] x;
        x = 32'(a);
        return {x[7:0] ^ 8'h5A, 32'hC0DE0000 ^ (x * 32'd2654435761), 16'h55AA, x[15:0]};
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MW; i++) bmem[i] = patt(i);
    endtask

    task automatic issue(int src, int dst, int len_m1);
        cmd_src   = AW'(src);
        cmd_dst   = AW'(dst);
        cmd_len   = AW'(len_m1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        check("R1 reset busy", DW'(cmd_busy), DW'(0));
        check("R8 reset done", DW'(done), DW'(0));
        check("R9 reset mem_en", DW'(mem_en), DW'(0));
        check("R5 reset stall", DW'(cpu_stall), DW'(0));
    endtask

    task automatic t_copy(int src, int dst, int n, string tag);
        int cyc;
        fill_mem();
        issue(src, dst, n - 1);
        check({tag, " R1 busy after accept"}, DW'(cmd_busy), DW'(1));
        wait_done(cyc);
        check({tag, " R3 cycles to done"}, DW'(cyc), DW'(2 * n + 1));
        @(negedge clk);
        check({tag, " R8 done one cycle"}, DW'(done), DW'(0));
        for (int i = 0; i < n; i++)
            check({tag, " R2 word"}, bmem[(dst + i) % MW], patt((src + i) % (1 << AW) % MW));
    endtask

    task automatic t_refuse();
        int cyc;
        int dones = 0;
        fill_mem();
        issue(20, 40, 3);
        cmd_src = 15'd60; cmd_dst = 15'd80; cmd_len = 15'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(cyc);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R7 no second done", DW'(dones), DW'(0));
        check("R7 busy dropped", DW'(cmd_busy), DW'(0));
        check("R7 dst untouched 80", bmem[80], patt(80));
        check("R7 dst untouched 81", bmem[81], patt(81));
        check("R7 first copy ok", bmem[43], patt(23));
    endtask

    task automatic t_interlock_read();
        int waited = 0;
        fill_mem();
        issue(200, 300, 15);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 15'd305;
        #1;
        check("R5 stall on pending dst", DW'(cpu_stall), DW'(1));
        while (cpu_stall && waited < 100) begin
            @(negedge clk);
            #1;
            waited++;
        end
        check("R6 dst word moved before grant", bmem[305], patt(205));
        check("R4 grant while busy", DW'(cmd_busy), DW'(1));
        @(negedge clk);
        cpu_req = 1'b0;
        check("R10 rvalid next cycle", DW'(cpu_rvalid), DW'(1));
        check("R6 read returns copied data", cpu_rdata, patt(205));
        while (cmd_busy) @(negedge clk);
    endtask

    task automatic t_interlock_write();
        int waited = 0;
        logic [DW-1:0] val;
        val = {DW{1'b1}} ^ 72'h1234;
        fill_mem();
        issue(400, 600, 15);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 15'd700;
        #1;
        check("R9 stall while engine owns port", DW'(cpu_stall), DW'(1));
        while (cpu_stall && waited < 10) begin
            @(negedge clk);
            #1;
            waited++;
        end
        check("R4 free read granted within a word", DW'(waited <= 3), DW'(1));
        check("R4 free read during transfer", DW'(cmd_busy), DW'(1));
        @(negedge clk);
        check("R10 free read data", cpu_rdata, patt(700));
        cpu_we = 1'b1; cpu_addr = 15'd405; cpu_wdata = val;
        #1;
        check("R5 stall on pending src", DW'(cpu_stall), DW'(1));
        waited = 0;
        while (cpu_stall && waited < 100) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        while (cmd_busy) @(negedge clk);
        check("R6 src write landed", bmem[405], val);
        check("R6 dst got old src value", bmem[605], patt(405));
    endtask

    task automatic t_full();
        int cyc;
        fill_mem();
        issue(0, 0, (1 << AW) - 1);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 15'd12345;
        #1;
        check("R5 full range stalls any address", DW'(cpu_stall), DW'(1));
        cpu_req = 1'b0;
        wait_done(cyc);
        check("R3 full memory cycles", DW'(cyc), DW'(2 * (1 << AW) + 1));
        cpu_req = 1'b1; cpu_addr = 15'd12345;
        #1;
        check("R8 interlock released at done", DW'(cpu_stall), DW'(0));
        @(negedge clk);
        cpu_req = 1'b0;
        check("R2 self copy intact", bmem[77], patt(77));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy(10, 100, 1, "single");
        t_copy(30, 130, 8, "eight");
        t_copy(32766, 16, 4, "wrap");
        t_refuse();
        t_interlock_read();
        t_interlock_write();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule